// File: doc/BRIEF.md
# Video Width Translation Bridge

This block converts the lane width of a video stream and keeps every timing event. Each input clock pulse (a cycle with `in_pulse` high) carries one unit of the input width, or a blanking slot when `in_de` is low. Line and frame start and end markers travel with it. A narrowing instance cuts each 64-bit or 32-bit unit into 16-bit beats. A widening instance gathers 16-bit beats into 64-bit words. Blanking slots are scaled by the same ratio as pixels, so the destination sees horizontal and vertical blanking in proportion to the source.

Accepted pulses pass through a small FIFO that absorbs rate mismatch. A converter state machine drains the FIFO. It is a splitter (states SER_IDLE and SER_SHIFT) when narrowing, and a gatherer (states PK_EMPTY and PK_FILL) when widening. The splitter moves from SER_IDLE to SER_SHIFT when it takes an entry. It stays in SER_SHIFT while back-to-back entries are waiting. It returns to SER_IDLE after its last sub-beat when the FIFO is empty, or on flush. The gatherer moves from PK_EMPTY to PK_FILL on a beat that leaves the word open. It returns to PK_EMPTY when a beat closes the word, or on flush.

There is no backpressure. When the FIFO is full, arriving pulses are dropped and a sticky interrupt is raised. A flush input discards everything in flight, for example before the source is switched over. Both sides run on one clock.

Top module: `vid_width_bridge`

## Requirements
- R1: Parameters `IN_W`/`OUT_W` select the ratio: 64→16 and 32→16 narrow, 16→64 widens. RATIO is the wider width divided by the narrower one.
- R2: When narrowing, each accepted pulse yields exactly RATIO output pulses on consecutive cycles. Bits [OUT_W-1:0] go out first, then the higher lanes in ascending order.
- R3: When narrowing, `out_de` repeats the input's data flag on every sub-beat. `out_hs` and `out_vs` appear only on the first sub-beat. `out_he` and `out_ve` appear only on the last sub-beat.
- R4: Blanking pulses (`in_de`=0) are never dropped by the converter. Narrowing turns one blank pulse into RATIO blank output pulses. Widening turns RATIO blank pulses into one blank output pulse with zero data.
- R5: When widening, the first beat of a group lands in bits [15:0] and later beats fill the next lanes upward. A word is emitted after RATIO beats. Its markers and `out_de` are the OR of the group's flags, and lanes from beats with `in_de`=0 are zero.
- R6: When widening, a beat carrying `in_he` or `in_ve` closes the word early. The unfilled upper lanes are zero.
- R7: With the FIFO empty and the converter idle, the first output pulse for a unit appears one cycle after the completing input pulse is sampled. A narrowing source that delivers one pulse every RATIO cycles gets an output pulse on every cycle, with no gaps.
- R8: A pulse that arrives while the FIFO holds FIFO_DEPTH entries is discarded, and `ovf_irq` is high from the next cycle on. `ovf_irq` stays set until it is cleared. It is 0 after reset.
- R9: `irq_clr` clears `ovf_irq` on the next cycle. If an overflow and `irq_clr` happen in the same cycle, the overflow wins and `ovf_irq` stays set.
- R10: `flush` empties the FIFO, aborts a split or a partial word, and clears `ovf_irq`. On the next cycle `out_pulse` is low. No unit accepted before the flush ever appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by source and destination sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all buffered and in-progress data, clear the interrupt |
| irq_clr | input | 1 | Clear the sticky overflow interrupt |
| in_pulse | input | 1 | One input clock pulse (data or blanking slot) |
| in_de | input | 1 | Pulse carries valid pixel data |
| in_hs | input | 1 | Line start marker |
| in_he | input | 1 | Line end marker |
| in_vs | input | 1 | Frame start marker |
| in_ve | input | 1 | Frame end marker |
| in_data | input | IN_W | Input unit |
| out_pulse | output | 1 | One output clock pulse |
| out_de | output | 1 | Output pulse carries pixel data |
| out_hs | output | 1 | Line start marker out |
| out_he | output | 1 | Line end marker out |
| out_vs | output | 1 | Frame start marker out |
| out_ve | output | 1 | Frame end marker out |
| out_data | output | OUT_W | Output unit |
| ovf_irq | output | 1 | Sticky FIFO overflow interrupt |

## Verification
An input pulse is sampled at a rising edge and lands in the FIFO. The converter takes it at the next edge. The first narrowed sub-beat, or a completed wide word, is therefore visible one cycle later. The remaining sub-beats follow on consecutive cycles. `ovf_irq` and the effect of `flush` or `irq_clr` show one cycle after the edge that samples them. The bench drives on falling edges and samples on falling edges. The latency and no-gap checks count these cycles exactly. The content checks compare the ordered output pulses, which a falling-edge monitor records, against expected beats that the bench computes. After a drop, the bench checks only properties that do not depend on how many pulses were dropped.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

    // Timing markers carried with every pulse
    typedef struct packed {
        logic de;
        logic hs;
        logic he;
        logic vs;
        logic ve;
    } vwb_mark_t;

    typedef enum logic {
        SER_IDLE,
        SER_SHIFT
    } ser_state_e;

    typedef enum logic {
        PK_EMPTY,
        PK_FILL
    } pk_state_e;

endpackage

// File: rtl/vwb_fifo.sv
module vwb_fifo #(
    parameter int unsigned W     = 69,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         drop
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign drop    = push && full;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8: the converter never takes an entry from an empty FIFO
    a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8: a dropped pulse leaves the FIFO full when nothing drains it
    a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));

endmodule

// File: rtl/vwb_serializer.sv
module vwb_serializer
    import vwb_pkg::*;
#(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fifo_empty,
    input  logic [IN_W-1:0]   fifo_data,
    input  vwb_mark_t         fifo_mark,
    output logic              fifo_pop,
    output logic              out_pulse,
    output logic [OUT_W-1:0]  out_data,
    output vwb_mark_t         out_mark
);
    localparam int unsigned RATIO = IN_W / OUT_W;
    localparam int unsigned IW    = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [IW-1:0] LAST = IW'(RATIO - 1);

    ser_state_e       state_q, state_d;
    logic [IN_W-1:0]  sh_q;
    vwb_mark_t        mk_q;
    logic [IW-1:0]    idx_q;
    logic             last_beat;

    assign last_beat = (state_q == SER_SHIFT) && (idx_q == LAST);
    assign fifo_pop  = !flush && !fifo_empty && ((state_q == SER_IDLE) || last_beat);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE: begin
                if (fifo_pop) state_d = SER_SHIFT;
            end
            SER_SHIFT: begin
                if (flush || (last_beat && !fifo_pop)) state_d = SER_IDLE;
            end
            default: state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            mk_q  <= '0;
            idx_q <= '0;
        end else if (fifo_pop) begin
            sh_q  <= fifo_data;
            mk_q  <= fifo_mark;
            idx_q <= '0;
        end else if (state_q == SER_SHIFT) begin
            sh_q  <= sh_q >> OUT_W;
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        out_pulse   = (state_q == SER_SHIFT);
        out_data    = sh_q[OUT_W-1:0];
        out_mark.de = mk_q.de;
        out_mark.hs = mk_q.hs && (idx_q == '0);
        out_mark.vs = mk_q.vs && (idx_q == '0);
        out_mark.he = mk_q.he && (idx_q == LAST);
        out_mark.ve = mk_q.ve && (idx_q == LAST);
    end

    // R3: start and end markers never share one sub-beat
    a_r3_start_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |-> !(out_mark.hs && out_mark.he) && !(out_mark.vs && out_mark.ve));

    // R2: a burst of sub-beats only stops after the last lane (unless flushed)
    a_r2_full_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_pulse) && !$past(flush)) |-> ($past(idx_q) == LAST));

endmodule

// File: rtl/vwb_packer.sv
module vwb_packer
    import vwb_pkg::*;
#(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fifo_empty,
    input  logic [IN_W-1:0]   fifo_data,
    input  vwb_mark_t         fifo_mark,
    output logic              fifo_pop,
    output logic              out_pulse,
    output logic [OUT_W-1:0]  out_data,
    output vwb_mark_t         out_mark
);
    localparam int unsigned RATIO = OUT_W / IN_W;
    localparam int unsigned IW    = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [IW-1:0] LAST = IW'(RATIO - 1);

    pk_state_e        state_q, state_d;
    logic [OUT_W-1:0] acc_q, lane_word, merged;
    vwb_mark_t        amk_q, merged_mk;
    logic [IW-1:0]    idx_q;
    logic             take, close;
    logic             oval_q;
    logic [OUT_W-1:0] odata_q;
    vwb_mark_t        omk_q;

    assign take     = !flush && !fifo_empty;
    assign fifo_pop = take;

    always_comb begin
        lane_word = OUT_W'(fifo_mark.de ? fifo_data : '0) << (int'(idx_q) * IN_W);
        merged    = acc_q | lane_word;
        merged_mk = vwb_mark_t'(amk_q | fifo_mark);
        close     = take && ((idx_q == LAST) || fifo_mark.he || fifo_mark.ve);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_EMPTY: begin
                if (take && !close) state_d = PK_FILL;
            end
            PK_FILL: begin
                if (flush || close) state_d = PK_EMPTY;
            end
            default: state_d = PK_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PK_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            amk_q   <= '0;
            idx_q   <= '0;
            oval_q  <= 1'b0;
            odata_q <= '0;
            omk_q   <= '0;
        end else if (flush) begin
            acc_q   <= '0;
            amk_q   <= '0;
            idx_q   <= '0;
            oval_q  <= 1'b0;
            odata_q <= '0;
            omk_q   <= '0;
        end else begin
            oval_q <= close;
            if (close) begin
                odata_q <= merged;
                omk_q   <= merged_mk;
                acc_q   <= '0;
                amk_q   <= '0;
                idx_q   <= '0;
            end else if (take) begin
                acc_q   <= merged;
                amk_q   <= merged_mk;
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        out_pulse = oval_q;
        out_data  = odata_q;
        out_mark  = omk_q;
    end

    // R4/R5: a word built only from blank slots carries zero data
    a_r5_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pulse && !out_mark.de) |-> (out_data == '0));

    // R6: an emitted word leaves the gatherer ready for a fresh group
    a_r6_restart_empty: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |-> (state_q == PK_EMPTY));

endmodule

// File: rtl/vid_width_bridge.sv
module vid_width_bridge
    import vwb_pkg::*;
#(
    parameter int unsigned IN_W       = 64,
    parameter int unsigned OUT_W      = 16,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              irq_clr,
    input  logic              in_pulse,
    input  logic              in_de,
    input  logic              in_hs,
    input  logic              in_he,
    input  logic              in_vs,
    input  logic              in_ve,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_pulse,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_he,
    output logic              out_vs,
    output logic              out_ve,
    output logic [OUT_W-1:0]  out_data,
    output logic              ovf_irq
);
    localparam bit          NARROW = (IN_W > OUT_W);
    localparam int unsigned MW     = $bits(vwb_mark_t);
    localparam int unsigned EW     = IN_W + MW;

    vwb_mark_t        in_mark, f_mark, o_mark;
    logic [EW-1:0]    f_dout;
    logic [IN_W-1:0]  f_data;
    logic             f_empty, f_drop, f_pop;
    logic             irq_q;

    assign in_mark = '{de: in_de, hs: in_hs, he: in_he, vs: in_vs, ve: in_ve};

    vwb_fifo #(
        .W     (EW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (in_pulse),
        .din   ({in_mark, in_data}),
        .pop   (f_pop),
        .dout  (f_dout),
        .empty (f_empty),
        .drop  (f_drop)
    );

    assign f_data = f_dout[IN_W-1:0];
    assign f_mark = vwb_mark_t'(f_dout[EW-1 -: MW]);

    generate
        if (NARROW) begin : g_narrow
            vwb_serializer #(
                .IN_W  (IN_W),
                .OUT_W (OUT_W)
            ) u_conv (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush      (flush),
                .fifo_empty (f_empty),
                .fifo_data  (f_data),
                .fifo_mark  (f_mark),
                .fifo_pop   (f_pop),
                .out_pulse  (out_pulse),
                .out_data   (out_data),
                .out_mark   (o_mark)
            );
        end else begin : g_widen
            vwb_packer #(
                .IN_W  (IN_W),
                .OUT_W (OUT_W)
            ) u_conv (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush      (flush),
                .fifo_empty (f_empty),
                .fifo_data  (f_data),
                .fifo_mark  (f_mark),
                .fifo_pop   (f_pop),
                .out_pulse  (out_pulse),
                .out_data   (out_data),
                .out_mark   (o_mark)
            );
        end
    endgenerate

    assign out_de = o_mark.de;
    assign out_hs = o_mark.hs;
    assign out_he = o_mark.he;
    assign out_vs = o_mark.vs;
    assign out_ve = o_mark.ve;

    // Sticky overflow flag: flush beats overflow, overflow beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (flush)   irq_q <= 1'b0;
        else if (f_drop)  irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end
    assign ovf_irq = irq_q;

    // R8: a dropped pulse raises the interrupt on the following cycle
    a_r8_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (f_drop && !flush) |=> ovf_irq);

    // R9: the interrupt holds until cleared or flushed
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && !irq_clr && !flush) |=> ovf_irq);

    // R10: flush silences the output and the interrupt one cycle later
    a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_pulse && !ovf_irq));

endmodule

// File: tb/vid_width_bridge_tb_top.sv
`timescale 1ns/1ps
module vid_width_bridge_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // DUT A: 64 -> 16
    logic        a_fl = 0, a_clr = 0, a_p = 0, a_de = 0, a_hs = 0, a_he = 0, a_vs = 0, a_ve = 0;
    logic [63:0] a_d = '0;
    logic        a_op, a_ode, a_ohs, a_ohe, a_ovs, a_ove, a_irq;
    logic [15:0] a_od;
    // DUT B: 32 -> 16
    logic        b_fl = 0, b_clr = 0, b_p = 0, b_de = 0, b_hs = 0, b_he = 0, b_vs = 0, b_ve = 0;
    logic [31:0] b_d = '0;
    logic        b_op, b_ode, b_ohs, b_ohe, b_ovs, b_ove, b_irq;
    logic [15:0] b_od;
    // DUT C: 16 -> 64
    logic        c_fl = 0, c_clr = 0, c_p = 0, c_de = 0, c_hs = 0, c_he = 0, c_vs = 0, c_ve = 0;
    logic [15:0] c_d = '0;
    logic        c_op, c_ode, c_ohs, c_ohe, c_ovs, c_ove, c_irq;
    logic [63:0] c_od;

    vid_width_bridge #(.IN_W(64), .OUT_W(16), .FIFO_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(a_fl), .irq_clr(a_clr), .in_pulse(a_p),
        .in_de(a_de), .in_hs(a_hs), .in_he(a_he), .in_vs(a_vs), .in_ve(a_ve), .in_data(a_d),
        .out_pulse(a_op), .out_de(a_ode), .out_hs(a_ohs), .out_he(a_ohe), .out_vs(a_ovs),
        .out_ve(a_ove), .out_data(a_od), .ovf_irq(a_irq));

    vid_width_bridge #(.IN_W(32), .OUT_W(16), .FIFO_DEPTH(4)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .flush(b_fl), .irq_clr(b_clr), .in_pulse(b_p),
        .in_de(b_de), .in_hs(b_hs), .in_he(b_he), .in_vs(b_vs), .in_ve(b_ve), .in_data(b_d),
        .out_pulse(b_op), .out_de(b_ode), .out_hs(b_ohs), .out_he(b_ohe), .out_vs(b_ovs),
        .out_ve(b_ove), .out_data(b_od), .ovf_irq(b_irq));

    vid_width_bridge #(.IN_W(16), .OUT_W(64), .FIFO_DEPTH(4)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .flush(c_fl), .irq_clr(c_clr), .in_pulse(c_p),
        .in_de(c_de), .in_hs(c_hs), .in_he(c_he), .in_vs(c_vs), .in_ve(c_ve), .in_data(c_d),
        .out_pulse(c_op), .out_de(c_ode), .out_hs(c_ohs), .out_he(c_ohe), .out_vs(c_ovs),
        .out_ve(c_ove), .out_data(c_od), .ovf_irq(c_irq));

    // Output capture, marks packed as {de,hs,he,vs,ve}
    logic [15:0] capa_d [128];
    logic [4:0]  capa_m [128];
    int          na = 0;
    logic [15:0] capb_d [32];
    logic [4:0]  capb_m [32];
    int          nb = 0;
    logic [63:0] capc_d [32];
    logic [4:0]  capc_m [32];
    int          nc = 0;

    always @(negedge clk) begin
        if (a_op) begin
            if (na < 128) begin
                capa_d[na] <= a_od;
                capa_m[na] <= {a_ode, a_ohs, a_ohe, a_ovs, a_ove};
            end
            na <= na + 1;
        end
        if (b_op) begin
            if (nb < 32) begin
                capb_d[nb] <= b_od;
                capb_m[nb] <= {b_ode, b_ohs, b_ohe, b_ovs, b_ove};
            end
            nb <= nb + 1;
        end
        if (c_op) begin
            if (nc < 32) begin
                capc_d[nc] <= c_od;
                capc_m[nc] <= {c_ode, c_ohs, c_ohe, c_ovs, c_ove};
            end
            nc <= nc + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic a_beat(input logic [4:0] m, input logic [63:0] d);
        {a_de, a_hs, a_he, a_vs, a_ve} = m; a_d = d; a_p = 1'b1;
        @(negedge clk);
        {a_de, a_hs, a_he, a_vs, a_ve} = '0; a_d = '0; a_p = 1'b0;
    endtask

    task automatic b_beat(input logic [4:0] m, input logic [31:0] d);
        {b_de, b_hs, b_he, b_vs, b_ve} = m; b_d = d; b_p = 1'b1;
        @(negedge clk);
        {b_de, b_hs, b_he, b_vs, b_ve} = '0; b_d = '0; b_p = 1'b0;
    endtask

    task automatic c_beat(input logic [4:0] m, input logic [15:0] d);
        {c_de, c_hs, c_he, c_vs, c_ve} = m; c_d = d; c_p = 1'b1;
        @(negedge clk);
        {c_de, c_hs, c_he, c_vs, c_ve} = '0; c_d = '0; c_p = 1'b0;
    endtask

    task automatic t_reset_state();
        check(a_op == 1'b0 && c_op == 1'b0, "R7 reset: no output pulse", {62'd0, a_op, c_op}, 64'd0);
        check(a_irq == 1'b0 && c_irq == 1'b0, "R8 reset: irq clear", {62'd0, a_irq, c_irq}, 64'd0);
    endtask

    task automatic t_narrow_split();
        int base;
        logic [15:0] ed [8];
        logic [4:0]  em [8];
        base = na;
        a_beat(5'b11010, 64'h4444_3333_2222_1111);
        a_beat(5'b10101, 64'hDDDD_CCCC_BBBB_AAAA);
        idle(12);
        check(na - base == 8, "R2 split count", 64'(na - base), 64'd8);
        ed = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD};
        em = '{5'b11010, 5'b10000, 5'b10000, 5'b10000, 5'b10000, 5'b10000, 5'b10000, 5'b10101};
        for (int i = 0; i < 8; i++) begin
            check(capa_d[base + i] == ed[i], "R2 lane order", 64'(capa_d[base + i]), 64'(ed[i]));
            check(capa_m[base + i] == em[i], "R3 marker placement", 64'(capa_m[base + i]), 64'(em[i]));
        end
    endtask

    task automatic t_latency_gapless();
        int ones = 0;
        for (int c = 0; c < 15; c++) begin
            if (c == 0 || c == 4 || c == 8) begin
                a_p = 1'b1; a_de = 1'b1; a_d = 64'h0008_0007_0006_0005 + 64'(c);
            end else begin
                a_p = 1'b0; a_de = 1'b0; a_d = '0;
            end
            if (c == 1) check(a_op == 1'b0, "R7 no output one edge after sample", 64'(a_op), 64'd0);
            if (c == 2) check(a_op == 1'b1 && a_od == 16'h0005, "R7 first sub-beat timing",
                              {47'd0, a_op, a_od}, {47'd0, 1'b1, 16'h0005});
            if (c >= 2 && c < 14) ones += int'(a_op);
            if (c == 14) check(a_op == 1'b0, "R7 burst ends", 64'(a_op), 64'd0);
            @(negedge clk);
        end
        check(ones == 12, "R7 gapless output", 64'(ones), 64'd12);
    endtask

    task automatic t_blank_narrow();
        int base;
        int bad = 0;
        base = na;
        a_beat(5'b00000, 64'd0);
        a_beat(5'b00000, 64'd0);
        a_beat(5'b00000, 64'd0);
        idle(16);
        check(na - base == 12, "R4 narrow blank scaling", 64'(na - base), 64'd12);
        for (int i = 0; i < 12; i++) if (capa_m[base + i][4]) bad++;
        check(bad == 0, "R4 narrow blank de low", 64'(bad), 64'd0);
    endtask

    task automatic t_ratio2();
        int base;
        base = nb;
        b_beat(5'b11100, 32'hBEEF_CAFE);
        idle(6);
        check(nb - base == 2, "R1 32to16 count", 64'(nb - base), 64'd2);
        check(capb_d[base] == 16'hCAFE && capb_d[base + 1] == 16'hBEEF, "R1 32to16 lanes",
              {32'd0, capb_d[base], capb_d[base + 1]}, 64'h0000_0000_CAFE_BEEF);
        check(capb_m[base] == 5'b11000 && capb_m[base + 1] == 5'b10100, "R3 32to16 markers",
              {54'd0, capb_m[base], capb_m[base + 1]}, {54'd0, 5'b11000, 5'b10100});
    endtask

    task automatic t_widen_full();
        int base;
        base = nc;
        c_beat(5'b11010, 16'h1111);
        c_beat(5'b10000, 16'h2222);
        c_beat(5'b10000, 16'h3333);
        check(c_op == 1'b0, "R5 no word before group complete", 64'(c_op), 64'd0);
        c_beat(5'b10000, 16'h4444);
        check(c_op == 1'b0, "R7 widen word not yet out", 64'(c_op), 64'd0);
        @(negedge clk);
        check(c_op == 1'b1, "R7 widen word timing", 64'(c_op), 64'd1);
        idle(4);
        check(nc - base == 1, "R5 widen count", 64'(nc - base), 64'd1);
        check(capc_d[base] == 64'h4444_3333_2222_1111, "R5 widen lane order", capc_d[base], 64'h4444_3333_2222_1111);
        check(capc_m[base] == 5'b11010, "R5 widen markers", 64'(capc_m[base]), 64'(5'b11010));
        base = nc;
        c_beat(5'b00000, 16'h5555);
        c_beat(5'b10000, 16'h6666);
        c_beat(5'b10000, 16'h6666);
        c_beat(5'b10000, 16'h6666);
        idle(4);
        check(capc_d[base] == 64'h6666_6666_6666_0000, "R5 blank lane zeroed", capc_d[base], 64'h6666_6666_6666_0000);
        check(capc_m[base] == 5'b10000, "R5 de is OR of group", 64'(capc_m[base]), 64'(5'b10000));
    endtask

    task automatic t_widen_early();
        int base;
        base = nc;
        c_beat(5'b10000, 16'hAAAA);
        c_beat(5'b10100, 16'hBBBB);
        idle(4);
        check(nc - base == 1, "R6 early close count", 64'(nc - base), 64'd1);
        check(capc_d[base] == 64'h0000_0000_BBBB_AAAA, "R6 zero pad", capc_d[base], 64'h0000_0000_BBBB_AAAA);
        check(capc_m[base] == 5'b10100, "R6 line end carried", 64'(capc_m[base]), 64'(5'b10100));
        base = nc;
        c_beat(5'b10001, 16'h7777);
        idle(4);
        check(capc_d[base] == 64'h0000_0000_0000_7777 && capc_m[base] == 5'b10001, "R6 frame end closes",
              capc_d[base], 64'h7777);
    endtask

    task automatic t_widen_blank();
        int base;
        base = nc;
        for (int i = 0; i < 8; i++) c_beat(5'b00000, 16'h0000);
        idle(4);
        check(nc - base == 2, "R4 widen blank scaling", 64'(nc - base), 64'd2);
        check(capc_m[base] == 5'b00000 && capc_d[base] == 64'd0, "R4 widen blank content",
              capc_d[base], 64'd0);
    endtask

    task automatic t_overflow();
        int base;
        base = na;
        for (int i = 0; i < 10; i++) a_beat(5'b10000, 64'h1000 + 64'(i));
        idle(50);
        check(a_irq == 1'b1, "R8 overflow raises irq", 64'(a_irq), 64'd1);
        check((na - base) % 4 == 0 && (na - base) < 40 && (na - base) >= 16, "R8 drops whole units",
              64'(na - base), 64'd16);
        check(capa_d[base] == 16'h1000, "R8 first accepted unit intact", 64'(capa_d[base]), 64'h1000);
        idle(10);
        check(a_irq == 1'b1, "R8 irq sticky", 64'(a_irq), 64'd1);
    endtask

    task automatic t_clear();
        a_clr = 1'b1;
        @(negedge clk);
        a_clr = 1'b0;
        check(a_irq == 1'b0, "R9 clear", 64'(a_irq), 64'd0);
        a_clr = 1'b1;
        for (int i = 0; i < 10; i++) a_beat(5'b10000, 64'h2000 + 64'(i));
        a_clr = 1'b0;
        check(a_irq == 1'b1, "R9 overflow wins over clear", 64'(a_irq), 64'd1);
        idle(50);
    endtask

    task automatic t_flush();
        int base;
        for (int i = 0; i < 8; i++) a_beat(5'b10000, 64'h3000 + 64'(i));
        a_fl = 1'b1;
        @(negedge clk);
        a_fl = 1'b0;
        check(a_op == 1'b0 && a_irq == 1'b0, "R10 flush quiet", {62'd0, a_op, a_irq}, 64'd0);
        base = na;
        idle(40);
        check(na == base, "R10 nothing after flush", 64'(na - base), 64'd0);
        a_beat(5'b11000, 64'h0004_0003_0002_0001);
        idle(8);
        check(na - base == 4 && capa_d[base] == 16'h0001 && capa_d[base + 3] == 16'h0004,
              "R10 clean restart", 64'(na - base), 64'd4);
        base = nc;
        c_beat(5'b10000, 16'hDEAD);
        c_beat(5'b10000, 16'hDEAD);
        c_fl = 1'b1;
        @(negedge clk);
        c_fl = 1'b0;
        c_beat(5'b10000, 16'h0001);
        c_beat(5'b10000, 16'h0002);
        c_beat(5'b10000, 16'h0003);
        c_beat(5'b10000, 16'h0004);
        idle(4);
        check(nc - base == 1 && capc_d[base] == 64'h0004_0003_0002_0001, "R10 partial word discarded",
              capc_d[base], 64'h0004_0003_0002_0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset_state();
        t_narrow_split();
        t_latency_gapless();
        t_blank_narrow();
        t_ratio2();
        t_widen_full();
        t_widen_early();
        t_widen_blank();
        t_overflow();
        t_clear();
        t_flush();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule